// File: doc/BRIEF.md
# Charge Counter with Capacity Learning

This block keeps a running tally of the charge left in a battery pack and learns how much charge the pack really holds. Three quantised pulse streams drive it: charge, discharge and self-discharge. Each stream has its own 8-bit efficiency factor `e`, and every pulse moves the tally by `(e+1)/256` of one count unit. The tally is held as a 16-bit integer count plus an 8-bit fraction, so partial pulses are never lost. The count is bounded below by zero and above by a learned capacity register.

When the count sits exactly at the learned capacity, a learning run arms. If the count is then discharged all the way to an integer value of zero, with no charge pulse and no host write in between, the block replaces the learned capacity with the total weighted discharge it measured over that run.

A small byte-wide host register port reads both bytes of the count and both bytes of the capacity. The port can write the count's high byte and either byte of the capacity. The count's low byte is read-only.

Top module: `charge_gauge`

## Requirements
- R1: After reset the count and its fraction are zero and the learned capacity equals the `INIT_CAP` parameter.
- R2: A lone charge pulse adds `chg_eff+1` to the 24-bit value {count, fraction}, so that a weight of 256 equals one count unit and the remainder carries into later pulses.
- R3: A discharge pulse subtracts `dsg_eff+1` and a self-discharge pulse subtracts `sdsg_eff+1` from the 24-bit value.
- R4: Pulses that arrive in the same cycle are summed with their signs and applied as a single update, so equal charge and discharge weights leave the value unchanged.
- R5: Each update saturates. The value never goes below zero, and it is never more than {capacity, 8'h00} except in the cycle right after a capacity write. `full` is high while count equals capacity, and `empty` is high while count is zero.
- R6: Register reads are combinational on `reg_addr`: 03h returns count[15:8], 17h returns count[7:0], 05h returns capacity[15:8] and 06h returns capacity[7:0]. Every other address reads 00h.
- R7: A write to 03h replaces count[15:8]. The lower count bits and the fraction are kept, and the result is clamped to the capacity. Pulses in that cycle are dropped. A write to 17h or to an unmapped address changes nothing, and pulses in that cycle apply normally.
- R8: A write to 05h or 06h replaces that byte of the capacity, and pulses in that cycle are dropped. If the count is above the new capacity, it is clamped on the following cycle.
- R9: A learning run starts in any cycle where count equals a non-zero capacity, and it discards whatever was measured before. The run adds up the discharge and self-discharge weights. In the cycle an update takes the count from non-zero to zero, the capacity becomes floor(total/256), with a floor of 1 and saturation at FFFFh.
- R10: A charge pulse, or an accepted write to 03h, 05h or 06h, ends a learning run without changing the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_pulse | input | 1 | One quantum of charge this cycle |
| dsg_pulse | input | 1 | One quantum of discharge this cycle |
| sdsg_pulse | input | 1 | One quantum of self-discharge this cycle |
| chg_eff | input | 8 | Charge efficiency factor (weight = value+1 of 256) |
| dsg_eff | input | 8 | Discharge efficiency factor |
| sdsg_eff | input | 8 | Self-discharge efficiency factor |
| reg_addr | input | 5 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr` |
| full | output | 1 | Count equals learned capacity |
| empty | output | 1 | Count integer part is zero |

## Verification
The hardest situation to reach from the ports is a completed learning run that actually moves the capacity. The count has to sit exactly at capacity, then drain to zero with no charge pulse and no write in between. The last update must also overshoot zero or end with a leftover fraction, so that the measured total differs from the old capacity.

The stimulus first forces the count to full with an oversized high-byte write. It then drains the count with unit-weight pulses and finishes with a combined discharge and self-discharge step, which pushes the capacity up by one. A second run uses a non-dividing weight, so the count reaches zero with a fraction left and the capacity drops. Aborted runs follow, and then a long pseudo-random mix on a small capacity that repeats many such cycles.

// File: rtl/gauge_pkg.sv
package gauge_pkg;

   localparam int EFF_W = 8;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CNT_HI,
      SEL_CNT_LO,
      SEL_CAP_HI,
      SEL_CAP_LO
   } reg_sel_e;

   // weight of one pulse in fraction units: factor + 1 (1..256)
   function automatic logic [EFF_W:0] pulse_weight(input logic [EFF_W-1:0] eff);
      return {1'b0, eff} + {{EFF_W{1'b0}}, 1'b1};
   endfunction

endpackage

// File: rtl/gauge_regs.sv
module gauge_regs
   import gauge_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int CNT_W    = 16,
   parameter int A_CNT_HI = 3,
   parameter int A_CNT_LO = 23,
   parameter int A_CAP_HI = 5,
   parameter int A_CAP_LO = 6,
   parameter int RD_REG   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [CNT_W-1:0]  cap_q,
   output logic              wr_cnt_hi,
   output logic              wr_cap_hi,
   output logic              wr_cap_lo,
   output logic              wr_any,
   output logic [7:0]        reg_rdata
);

   localparam logic [ADDR_W-1:0] L_CNT_HI = ADDR_W'(A_CNT_HI);
   localparam logic [ADDR_W-1:0] L_CNT_LO = ADDR_W'(A_CNT_LO);
   localparam logic [ADDR_W-1:0] L_CAP_HI = ADDR_W'(A_CAP_HI);
   localparam logic [ADDR_W-1:0] L_CAP_LO = ADDR_W'(A_CAP_LO);

   reg_sel_e   sel;
   logic [7:0] rd_mux;

   always_comb begin
      sel = SEL_NONE;
      if (reg_addr == L_CNT_HI)      sel = SEL_CNT_HI;
      else if (reg_addr == L_CNT_LO) sel = SEL_CNT_LO;
      else if (reg_addr == L_CAP_HI) sel = SEL_CAP_HI;
      else if (reg_addr == L_CAP_LO) sel = SEL_CAP_LO;
   end

   assign wr_cnt_hi = reg_wr && (sel == SEL_CNT_HI);
   assign wr_cap_hi = reg_wr && (sel == SEL_CAP_HI);
   assign wr_cap_lo = reg_wr && (sel == SEL_CAP_LO);
   assign wr_any    = wr_cnt_hi || wr_cap_hi || wr_cap_lo;

   always_comb begin
      case (sel)
         SEL_CNT_HI: rd_mux = cnt_q[CNT_W-1 -: 8];
         SEL_CNT_LO: rd_mux = cnt_q[7:0];
         SEL_CAP_HI: rd_mux = cap_q[CNT_W-1 -: 8];
         SEL_CAP_LO: rd_mux = cap_q[7:0];
         default:    rd_mux = 8'h00;
      endcase
   end

   generate
      if (RD_REG != 0) begin : g_rd_reg
         logic [7:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= 8'h00;
            else        rd_q <= rd_mux;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate

endmodule

// File: rtl/gauge_step.sv
module gauge_step
   import gauge_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int FRAC_W = EFF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chg_pulse,
   input  logic                    dsg_pulse,
   input  logic                    sdsg_pulse,
   input  logic [FRAC_W-1:0]       chg_eff,
   input  logic [FRAC_W-1:0]       dsg_eff,
   input  logic [FRAC_W-1:0]       sdsg_eff,
   input  logic                    wr_cnt_hi,
   input  logic                    wr_any,
   input  logic [7:0]              wr_data,
   input  logic [CNT_W-1:0]        cap_q,
   output logic [CNT_W+FRAC_W-1:0] sub_q,
   output logic [CNT_W+FRAC_W-1:0] sub_nxt,
   output logic [FRAC_W+1:0]       dis_w
);

   localparam int SUB_W = CNT_W + FRAC_W;
   localparam int EXT_W = SUB_W + 2;

   logic [FRAC_W:0]          chg_w;
   logic [FRAC_W+1:0]        add_w;
   logic [FRAC_W+1:0]        rem_w;
   logic [SUB_W-1:0]         base;
   logic signed [EXT_W-1:0]  sum_s;
   logic signed [EXT_W-1:0]  lim_s;

   assign chg_w = chg_pulse ? pulse_weight(chg_eff) : '0;
   assign dis_w = (dsg_pulse  ? {1'b0, pulse_weight(dsg_eff)}  : '0)
                + (sdsg_pulse ? {1'b0, pulse_weight(sdsg_eff)} : '0);

   // a host write owns the cycle: pulses are dropped
   assign add_w = wr_any ? '0 : {1'b0, chg_w};
   assign rem_w = wr_any ? '0 : dis_w;
   assign base  = wr_cnt_hi ? {wr_data, sub_q[SUB_W-9:0]} : sub_q;

   always_comb begin
      sum_s = $signed({2'b00, base}) + $signed(EXT_W'(add_w)) - $signed(EXT_W'(rem_w));
      lim_s = $signed({2'b00, cap_q, {FRAC_W{1'b0}}});
      if (sum_s[EXT_W-1])     sub_nxt = '0;
      else if (sum_s > lim_s) sub_nxt = lim_s[SUB_W-1:0];
      else                    sub_nxt = sum_s[SUB_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sub_q <= '0;
      else        sub_q <= sub_nxt;
   end

endmodule

// File: rtl/gauge_learn.sv
module gauge_learn #(
   parameter int CNT_W    = 16,
   parameter int FRAC_W   = 8,
   parameter int INIT_CAP = 2048
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chg_pulse,
   input  logic                    wr_any,
   input  logic                    wr_cap_hi,
   input  logic                    wr_cap_lo,
   input  logic [7:0]              wr_data,
   input  logic [FRAC_W+1:0]       dis_w,
   input  logic [CNT_W+FRAC_W-1:0] sub_q,
   input  logic [CNT_W+FRAC_W-1:0] sub_nxt,
   output logic [CNT_W-1:0]        cap_q,
   output logic                    learn_act
);

   localparam int SUB_W  = CNT_W + FRAC_W;
   localparam int MEAS_W = SUB_W + 2;
   localparam int LRN_W  = MEAS_W - FRAC_W;

   logic [CNT_W-1:0]  cnt_now;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              at_full;
   logic              elig;
   logic              done;
   logic [MEAS_W-1:0] meas_q;
   logic [MEAS_W-1:0] meas_sum;
   logic [LRN_W-1:0]  learned;
   logic [CNT_W-1:0]  learned_sat;

   assign cnt_now  = sub_q[SUB_W-1:FRAC_W];
   assign cnt_nxt  = sub_nxt[SUB_W-1:FRAC_W];
   assign at_full  = (cnt_now == cap_q) && (cap_q != '0);
   assign elig     = (learn_act || at_full) && !chg_pulse && !wr_any;
   assign meas_sum = (at_full ? '0 : meas_q) + MEAS_W'(dis_w);
   assign done     = elig && (cnt_nxt == '0) && (cnt_now != '0);
   assign learned  = meas_sum[MEAS_W-1:FRAC_W];

   always_comb begin
      if (|learned[LRN_W-1:CNT_W])        learned_sat = '1;
      else if (learned[CNT_W-1:0] == '0)  learned_sat = CNT_W'(1);
      else                                learned_sat = learned[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q     <= CNT_W'(INIT_CAP);
         learn_act <= 1'b0;
         meas_q    <= '0;
      end else begin
         if (wr_cap_hi) cap_q[CNT_W-1 -: 8] <= wr_data;
         if (wr_cap_lo) cap_q[7:0]          <= wr_data;
         if (done)      cap_q               <= learned_sat;
         learn_act <= elig && !done;
         meas_q    <= (elig && !done) ? meas_sum : '0;
      end
   end

endmodule

// File: rtl/charge_gauge.sv
module charge_gauge
   import gauge_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int FRAC_W   = EFF_W,
   parameter int ADDR_W   = 5,
   parameter int A_CNT_HI = 3,
   parameter int A_CNT_LO = 23,
   parameter int A_CAP_HI = 5,
   parameter int A_CAP_LO = 6,
   parameter int INIT_CAP = 2048,
   parameter int RD_REG   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chg_pulse,
   input  logic              dsg_pulse,
   input  logic              sdsg_pulse,
   input  logic [FRAC_W-1:0] chg_eff,
   input  logic [FRAC_W-1:0] dsg_eff,
   input  logic [FRAC_W-1:0] sdsg_eff,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              full,
   output logic              empty
);

   localparam int SUB_W = CNT_W + FRAC_W;

   generate
      if (CNT_W != 16) begin : g_chk_cnt
         $error("charge_gauge: CNT_W must be two host bytes");
      end
      if (FRAC_W != EFF_W) begin : g_chk_frac
         $error("charge_gauge: FRAC_W must match the efficiency width");
      end
      if (INIT_CAP < 0 || INIT_CAP >= (1 << CNT_W)) begin : g_chk_init
         $error("charge_gauge: INIT_CAP out of range");
      end
      if (A_CNT_HI >= (1 << ADDR_W) || A_CNT_LO >= (1 << ADDR_W) ||
          A_CAP_HI >= (1 << ADDR_W) || A_CAP_LO >= (1 << ADDR_W)) begin : g_chk_addr
         $error("charge_gauge: register address exceeds ADDR_W");
      end
      if (A_CNT_HI == A_CNT_LO || A_CNT_HI == A_CAP_HI || A_CNT_HI == A_CAP_LO ||
          A_CNT_LO == A_CAP_HI || A_CNT_LO == A_CAP_LO || A_CAP_HI == A_CAP_LO) begin : g_chk_uniq
         $error("charge_gauge: register addresses overlap");
      end
   endgenerate

   logic [SUB_W-1:0]  sub_q;
   logic [SUB_W-1:0]  sub_nxt;
   logic [FRAC_W+1:0] dis_w;
   logic [CNT_W-1:0]  cap_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              learn_act;
   logic              wr_cnt_hi;
   logic              wr_cap_hi;
   logic              wr_cap_lo;
   logic              wr_any;

   assign cnt_q = sub_q[SUB_W-1:FRAC_W];
   assign full  = (cnt_q == cap_q);
   assign empty = (cnt_q == '0);

   gauge_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .A_CNT_HI(A_CNT_HI), .A_CNT_LO(A_CNT_LO),
      .A_CAP_HI(A_CAP_HI), .A_CAP_LO(A_CAP_LO),
      .RD_REG(RD_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wr(reg_wr),
      .cnt_q(cnt_q), .cap_q(cap_q),
      .wr_cnt_hi(wr_cnt_hi), .wr_cap_hi(wr_cap_hi), .wr_cap_lo(wr_cap_lo),
      .wr_any(wr_any), .reg_rdata(reg_rdata)
   );

   gauge_step #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_step (
      .clk(clk), .rst_n(rst_n),
      .chg_pulse(chg_pulse), .dsg_pulse(dsg_pulse), .sdsg_pulse(sdsg_pulse),
      .chg_eff(chg_eff), .dsg_eff(dsg_eff), .sdsg_eff(sdsg_eff),
      .wr_cnt_hi(wr_cnt_hi), .wr_any(wr_any), .wr_data(reg_wdata),
      .cap_q(cap_q), .sub_q(sub_q), .sub_nxt(sub_nxt), .dis_w(dis_w)
   );

   gauge_learn #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .INIT_CAP(INIT_CAP)) u_learn (
      .clk(clk), .rst_n(rst_n),
      .chg_pulse(chg_pulse), .wr_any(wr_any),
      .wr_cap_hi(wr_cap_hi), .wr_cap_lo(wr_cap_lo), .wr_data(reg_wdata),
      .dis_w(dis_w), .sub_q(sub_q), .sub_nxt(sub_nxt),
      .cap_q(cap_q), .learn_act(learn_act)
   );

endmodule

// File: rtl/charge_gauge_chk.sv
module charge_gauge_chk #(
   parameter int CNT_W    = 16,
   parameter int FRAC_W   = 8,
   parameter int ADDR_W   = 5,
   parameter int A_CNT_HI = 3,
   parameter int A_CNT_LO = 23,
   parameter int A_CAP_HI = 5,
   parameter int A_CAP_LO = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    chg_pulse,
   input logic                    dsg_pulse,
   input logic                    sdsg_pulse,
   input logic [FRAC_W-1:0]       chg_eff,
   input logic [FRAC_W-1:0]       dsg_eff,
   input logic [ADDR_W-1:0]       reg_addr,
   input logic                    reg_wr,
   input logic [CNT_W+FRAC_W-1:0] sub_q,
   input logic [CNT_W-1:0]        cap_q,
   input logic                    learn_act
);

   localparam int SUB_W = CNT_W + FRAC_W;

   logic [SUB_W-1:0] cap_sub;
   logic             cap_wr;
   logic             any_wr;
   logic             no_pulse;

   assign cap_sub  = {cap_q, {FRAC_W{1'b0}}};
   assign cap_wr   = reg_wr && (reg_addr == ADDR_W'(A_CAP_HI) || reg_addr == ADDR_W'(A_CAP_LO));
   assign any_wr   = cap_wr || (reg_wr && reg_addr == ADDR_W'(A_CNT_HI));
   assign no_pulse = !chg_pulse && !dsg_pulse && !sdsg_pulse;

   p_chg_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_pulse && !dsg_pulse && !sdsg_pulse && !any_wr && sub_q <= cap_sub)
      |=> (sub_q >= $past(sub_q)));

   p_dsg_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg_pulse && (dsg_pulse || sdsg_pulse) && !any_wr)
      |=> (sub_q <= $past(sub_q)));

   p_net_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_pulse && dsg_pulse && !sdsg_pulse && chg_eff == dsg_eff && !any_wr && sub_q <= cap_sub)
      |=> $stable(sub_q));

   p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_q > cap_sub) |-> $past(cap_wr));

   p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (no_pulse && !any_wr && sub_q <= cap_sub) |=> $stable(sub_q));

   p_lo_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(A_CNT_LO) && no_pulse && sub_q <= cap_sub)
      |=> $stable(sub_q));

   p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_wr && !dsg_pulse && !sdsg_pulse) |=> $stable(cap_q));

   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_pulse || any_wr) |=> !learn_act);

endmodule

bind charge_gauge charge_gauge_chk #(
   .CNT_W(CNT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W),
   .A_CNT_HI(A_CNT_HI), .A_CNT_LO(A_CNT_LO),
   .A_CAP_HI(A_CAP_HI), .A_CAP_LO(A_CAP_LO)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .chg_pulse(chg_pulse), .dsg_pulse(dsg_pulse), .sdsg_pulse(sdsg_pulse),
   .chg_eff(chg_eff), .dsg_eff(dsg_eff),
   .reg_addr(reg_addr), .reg_wr(reg_wr),
   .sub_q(sub_q), .cap_q(cap_q), .learn_act(learn_act)
);

// File: tb/charge_gauge_bench.sv
module charge_gauge_bench;

   localparam int A_HI = 3;
   localparam int A_LO = 23;
   localparam int A_CH = 5;
   localparam int A_CL = 6;
   localparam int INIT = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chg_pulse = 1'b0, dsg_pulse = 1'b0, sdsg_pulse = 1'b0;
   logic [7:0] chg_eff = 8'hFF, dsg_eff = 8'hFF, sdsg_eff = 8'hFF;
   logic [4:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       full, empty;

   charge_gauge #(.INIT_CAP(INIT)) u_charge_gauge (
      .clk(clk), .rst_n(rst_n),
      .chg_pulse(chg_pulse), .dsg_pulse(dsg_pulse), .sdsg_pulse(sdsg_pulse),
      .chg_eff(chg_eff), .dsg_eff(dsg_eff), .sdsg_eff(sdsg_eff),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .full(full), .empty(empty)
   );

   always #10 clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   int m_sub = 0, m_cap = INIT, m_act = 0, m_meas = 0;
   int seed = 32'h1234_5678;
   bit finished = 0;

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // expected next state, computed from the requirement arithmetic
   task automatic model(input bit c, input bit d, input bit s, input bit we, input int wa, input int wd);
      int cw, dw, sw, dis, capsub, n, ms, lc;
      bit acc, start, elig;
      cw = int'(chg_eff) + 1;
      dw = int'(dsg_eff) + 1;
      sw = int'(sdsg_eff) + 1;
      acc = we && (wa == A_HI || wa == A_CH || wa == A_CL);
      capsub = m_cap * 256;
      start = ((m_sub >> 8) == m_cap) && (m_cap != 0);
      dis = (d ? dw : 0) + (s ? sw : 0);
      if (acc) begin
         n = m_sub;
         if (wa == A_HI) n = (wd << 16) | (m_sub & 'hFFFF);
      end else begin
         n = m_sub + (c ? cw : 0) - dis;
      end
      if (n < 0) n = 0;
      if (n > capsub) n = capsub;
      elig = (m_act != 0 || start) && !c && !acc;
      ms = (start ? 0 : m_meas) + dis;
      if (elig && (n >> 8) == 0 && (m_sub >> 8) != 0) begin
         lc = ms >> 8;
         if (lc == 0) lc = 1;
         if (lc > 65535) lc = 65535;
         m_cap = lc; m_act = 0; m_meas = 0;
      end else if (elig) begin
         m_act = 1; m_meas = ms;
      end else begin
         m_act = 0; m_meas = 0;
      end
      if (acc && wa == A_CH) m_cap = (wd << 8) | (m_cap & 'hFF);
      if (acc && wa == A_CL) m_cap = (m_cap & 'hFF00) | wd;
      m_sub = n;
   endtask

   task automatic rd(input int a, output int v);
      reg_addr = 5'(a);
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic check(input string tag);
      int hi, lo, ch, cl, gc, gp, ec;
      bit ef, ee;
      rd(A_HI, hi); rd(A_LO, lo); rd(A_CH, ch); rd(A_CL, cl);
      gc = (hi << 8) | lo;
      gp = (ch << 8) | cl;
      ec = m_sub >> 8;
      ef = (ec == m_cap);
      ee = (ec == 0);
      n_vec++;
      if (gc != ec || gp != m_cap || full != ef || empty != ee) begin
         n_bad++;
         $display("FAIL %s: cnt=%h cap=%h full=%b empty=%b expected cnt=%h cap=%h full=%b empty=%b",
                  tag, gc, gp, full, empty, ec, m_cap, ef, ee);
      end
   endtask

   task automatic step(input bit c, input bit d, input bit s, input bit we,
                       input int wa, input int wd, input string tag);
      @(negedge clk);
      chg_pulse = c; dsg_pulse = d; sdsg_pulse = s;
      reg_wr = we; reg_addr = 5'(wa); reg_wdata = 8'(wd);
      model(c, d, s, we, wa, wd);
      @(posedge clk);
      #2;
      chg_pulse = 0; dsg_pulse = 0; sdsg_pulse = 0; reg_wr = 0;
      check(tag);
   endtask

   task automatic rd_zero(input int a);
      int v;
      rd(a, v);
      n_vec++;
      if (v != 0) begin
         n_bad++;
         $display("FAIL R6: addr %0d read %h expected 00", a, v);
      end
   endtask

   function automatic int rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      return seed & 32'h7FFF_FFFF;
   endfunction

   initial begin
      #(200000 * 20);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1");
      rd_zero(0); rd_zero(31); rd_zero(4);

      // widen capacity so the sweeps run unclamped
      step(0, 0, 0, 1, A_CH, 8'hFF, "R8");
      step(0, 0, 0, 1, A_CL, 8'hFF, "R8");

      // charge sweep over every factor; remainder carries between pulses
      for (int e = 0; e < 256; e++) begin
         chg_eff = 8'(e);
         step(1, 0, 0, 0, 0, 0, "R2");
      end

      // discharge / self-discharge sweep, ends clamped at zero
      for (int e = 0; e < 256; e++) begin
         dsg_eff  = 8'(e);
         sdsg_eff = 8'(255 - e);
         step(0, 1, (e % 2) == 1, 0, 0, 0, "R3");
      end

      // every pulse combination under several factor sets
      step(0, 0, 0, 1, A_HI, 8'h40, "R7");
      for (int k = 0; k < 4; k++) begin
         for (int combo = 0; combo < 8; combo++) begin
            chg_eff  = (k == 0) ? 8'd0 : (k == 1) ? 8'd37 : (k == 2) ? 8'd128 : 8'd255;
            dsg_eff  = (k == 3) ? chg_eff : 8'(255 - int'(chg_eff));
            sdsg_eff = chg_eff ^ 8'h5A;
            step(combo[0], combo[1], combo[2], 0, 0, 0, "R4");
         end
      end

      // read-only low byte, high byte write drops pulses
      step(0, 0, 0, 1, A_LO, 8'hAA, "R7");
      step(1, 0, 0, 1, A_LO, 8'h55, "R7");
      step(1, 1, 0, 1, A_HI, 8'h12, "R7");
      step(0, 0, 0, 1, 9, 8'h77, "R6");

      // shrink capacity: count clamps on the following cycle
      step(0, 0, 0, 1, A_CH, 8'h00, "R8");
      step(0, 0, 0, 1, A_CL, 8'd10, "R8");
      step(0, 0, 0, 0, 0, 0, "R8");
      chg_eff = 8'hFF; dsg_eff = 8'hFF; sdsg_eff = 8'hFF;
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R5");
      for (int i = 0; i < 14; i++) step(0, 1, 0, 0, 0, 0, "R5");
      for (int i = 0; i < 14; i++) step(1, 0, 0, 0, 0, 0, "R5");

      // oversized high-byte write clamps to capacity (full)
      step(0, 0, 0, 1, A_HI, 8'hFF, "R7");

      // qualified run ending with an overshoot -> capacity grows
      for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0, 0, "R9");
      step(0, 1, 1, 0, 0, 0, "R9");

      // aborted run: a charge pulse mid-way
      for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 0, "R10");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R10");
      step(1, 0, 0, 0, 0, 0, "R10");
      for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 0, 0, "R10");

      // aborted run: capacity write mid-way (same value)
      for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 0, "R10");
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0, "R10");
      step(0, 0, 0, 1, A_CL, m_cap & 255, "R10");
      for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 0, 0, "R10");

      // half-weight pulses, exact landing
      for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 0, "R9");
      dsg_eff = 8'd127;
      for (int i = 0; i < 24; i++) step(0, 1, 0, 0, 0, 0, "R9");

      // non-dividing weight: zero reached with a fraction left -> capacity shrinks
      for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 0, "R9");
      sdsg_eff = 8'd99;
      for (int i = 0; i < 30; i++) step(0, 0, 1, 0, 0, 0, "R9");

      // long pseudo-random mix on a small capacity
      step(0, 0, 0, 1, A_CL, 8'd6, "R8");
      for (int i = 0; i < 3000; i++) begin
         int r, w, wa;
         r = rnd();
         chg_eff  = 8'(r >> 3);
         dsg_eff  = 8'(r >> 11);
         sdsg_eff = 8'(r >> 19);
         w = ((r >> 27) & 15) == 0;
         case ((r >> 1) & 7)
            0, 1:    wa = A_HI;
            2:       wa = A_LO;
            3:       wa = A_CH;
            4, 5:    wa = A_CL;
            default: wa = 0;
         endcase
         step((r & 7) == 0, ((r >> 4) & 3) == 0, ((r >> 6) & 7) == 0, w != 0, wa,
              (wa == A_CH) ? 0 : ((r >> 9) & 15), "R5");
      end

      summary();
   end

endmodule